// File: doc/BRIEF.md
# Serial Register Preload and Observe Chain

This block links every user register of a quadrant-organised logic array into one serial shift path for test. When the scan mode is active, each rising edge of a slow test clock moves the serial input into the first register of the path. Every other register takes the value of the register before it, and the last register drives the serial output. Contents therefore leave in first-in first-out order. Tying the serial output back to the serial input lets a tester read the whole state without losing it. Holding the output enable inactive gives a load-only mode.

Outside scan mode the registers run their normal function. Each register is either a D-type or a toggle-type, chosen by a per-register configuration bit. The scan mode is modelled as a plain digital request. A lock input makes the request have no effect. A sticky flag records any entry to or exit from the mode while a user register clock, or the test clock, is high.

The registers are held in scan order. The parallel output vector is in natural order: within quadrant q, I/O cell c owns bits q*QLEN+2c (first register) and q*QLEN+2c+1 (second register), and buried register b owns bit q*QLEN+2*IOC+b, where QLEN = 2*IOC+BUR.

Top module: `scan_preload_ctrl`

## Requirements
- R1: After reset all register bits, `viol_o`, `sdo_o` and `sdo_en_o` are 0.
- R2: While the scan mode is active (`test_mode_i`=1 and `lock_i`=0), each low-to-high change of `tck_i` seen at a `clk` edge shifts the chain by exactly one position: scan position 0 takes `sdi_i` and position p takes the old value of position p-1. Holding `tck_i` high causes no further shifts.
- R3: The scan order runs through the quadrants in ascending order. Within a quadrant it visits, for each I/O cell in ascending order, the first register and then the second register. After each odd-numbered cell c it inserts buried register (c-1)/2, while buried registers remain. With the defaults, scan positions 0, 1, 4, 5, 29, 31, 32, 36 and 127 map to natural bits 0, 1, 26, 4, 31, 25, 32, 58 and 121.
- R4: While active, `sdo_o` carries the register at the last scan position, so the bits leave in the order they were shifted in. Shifting NREG times with `sdi_i` tied to `sdo_o` leaves every register unchanged.
- R5: A shifted bit is stored exactly as given, even in registers configured as toggle-type.
- R6: `sdo_en_o` is 1 only when the mode is active and `sdo_oe_n_i`=0. With `sdo_oe_n_i`=1, shifting still loads the chain.
- R7: With `lock_i`=1, `tck_i` pulses shift nothing, `sdo_en_o` stays 0 and the normal register function continues.
- R8: `viol_o` becomes 1 when the active state changes at a clock edge while any `usr_clk_i` bit or `tck_i` is 1. It stays 1 until reset.
- R9: While active, the normal register updates are frozen. After exit, the registers keep their shifted values and normal updates resume: when `func_en_i` is set, a D-type register loads `func_d_i`, and a toggle-type register (`cfg_t_i`=1) inverts when `func_d_i`=1.
- R10: `sdo_o` is 0 whenever the mode is not active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset, clears all registers |
| func_en_i | input | NREG | Per-register normal-mode update enable |
| func_d_i | input | NREG | Per-register normal-mode data |
| cfg_t_i | input | NREG | Per-register toggle-type select (0 = D-type) |
| usr_clk_i | input | NQUAD | Quadrant register clock levels, checked on mode change |
| test_mode_i | input | 1 | Scan mode request |
| tck_i | input | 1 | Test shift clock, sampled by `clk` |
| sdi_i | input | 1 | Serial data in |
| sdo_oe_n_i | input | 1 | Serial output enable, active low |
| lock_i | input | 1 | Security lock, disables the scan mode |
| regs_o | output | NREG | Register contents in natural order |
| sdo_o | output | 1 | Serial data out |
| sdo_en_o | output | 1 | Serial output drive enable |
| viol_o | output | 1 | Sticky clock-rule violation flag |

## Verification
The hardest property to reach from the ports is the exact placement of every register in the scan order. A single shift leaves no visible trace unless a lone marker bit is walked to a known depth. The bench therefore resets the block, shifts in a single one followed by a table-defined number of zeros, and checks that exactly one natural bit is set. This is done for positions at the quadrant seams and at the buried-register insertions. Lossless observation is reached by preloading a full irregular pattern into toggle-type registers and then circulating it once through the loopback.

// File: rtl/scan_pkg.sv
package scan_pkg;

  // Map a scan position to a natural register index.
  // Per quadrant: pairs of I/O cells form blocks of five positions
  // (4 I/O registers, then one buried register); remaining cells follow.
  function automatic int nat_of_pos(input int pos, input int ioc, input int bur);
    int qlen;
    int q;
    int r;
    int loc;
    qlen = 2 * ioc + bur;
    q    = pos / qlen;
    r    = pos % qlen;
    if (r < 5 * bur) begin
      if (r % 5 == 4) loc = 2 * ioc + r / 5;
      else            loc = 4 * (r / 5) + r % 5;
    end else begin
      loc = 4 * bur + (r - 5 * bur);
    end
    return q * qlen + loc;
  endfunction

  // Normal-mode next state of one register.
  function automatic logic func_next(input logic q, input logic en,
                                     input logic d, input logic tgl);
    if (!en) return q;
    return tgl ? (q ^ d) : d;
  endfunction

endpackage

// File: rtl/scan_edge_det.sv
module scan_edge_det #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sig_i,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] chg_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= sig_i;
  end

  assign rise_o = sig_i & ~prev_q;
  assign chg_o  = sig_i ^ prev_q;
endmodule

// File: rtl/scan_reg_bank.sv
module scan_reg_bank
  import scan_pkg::*;
#(
  parameter int NQUAD = 4,
  parameter int IOC   = 13,
  parameter int BUR   = 6,
  localparam int NREG = NQUAD * (2 * IOC + BUR)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            shift_i,
  input  logic            freeze_i,
  input  logic            sdi_i,
  input  logic [NREG-1:0] func_en_i,
  input  logic [NREG-1:0] func_d_i,
  input  logic [NREG-1:0] cfg_t_i,
  output logic [NREG-1:0] regs_o,
  output logic            tail_o
);
  // storage kept in scan order; bit 0 is the chain head
  logic [NREG-1:0] sc_q;
  logic [NREG-1:0] sc_d;

  for (genvar p = 0; p < NREG; p++) begin : g_pos
    localparam int N = nat_of_pos(p, IOC, BUR);
    logic upstream;
    if (p == 0) begin : g_head
      assign upstream = sdi_i;
    end else begin : g_body
      assign upstream = sc_q[p-1];
    end
    always_comb begin
      if (shift_i)       sc_d[p] = upstream;
      else if (freeze_i) sc_d[p] = sc_q[p];
      else               sc_d[p] = func_next(sc_q[p], func_en_i[N], func_d_i[N], cfg_t_i[N]);
    end
    assign regs_o[N] = sc_q[p];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sc_q <= '0;
    else        sc_q <= sc_d;
  end

  assign tail_o = sc_q[NREG-1];
endmodule

// File: rtl/scan_viol_mon.sv
module scan_viol_mon #(
  parameter int NQUAD = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_chg_i,
  input  logic [NQUAD-1:0] usr_clk_i,
  input  logic             tck_i,
  output logic             viol_o
);
  logic clk_high;
  assign clk_high = (|usr_clk_i) | tck_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      viol_o <= 1'b0;
    else if (mode_chg_i && clk_high) viol_o <= 1'b1;
  end
endmodule

// File: rtl/scan_preload_ctrl.sv
module scan_preload_ctrl #(
  parameter int NQUAD = 4,
  parameter int IOC   = 13,
  parameter int BUR   = 6,
  localparam int NREG = NQUAD * (2 * IOC + BUR)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NREG-1:0]  func_en_i,
  input  logic [NREG-1:0]  func_d_i,
  input  logic [NREG-1:0]  cfg_t_i,
  input  logic [NQUAD-1:0] usr_clk_i,
  input  logic             test_mode_i,
  input  logic             tck_i,
  input  logic             sdi_i,
  input  logic             sdo_oe_n_i,
  input  logic             lock_i,
  output logic [NREG-1:0]  regs_o,
  output logic             sdo_o,
  output logic             sdo_en_o,
  output logic             viol_o
);
  // named internal events, used by the bound checker
  logic active;
  logic shift_pulse;
  logic mode_chg;
  logic tail;
  logic [1:0] ev_rise;
  logic [1:0] ev_chg;

  assign active = test_mode_i & ~lock_i;

  scan_edge_det #(.W(2)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .sig_i  ({active, tck_i}),
    .rise_o (ev_rise),
    .chg_o  (ev_chg)
  );

  assign shift_pulse = active & ev_rise[0];
  assign mode_chg    = ev_chg[1];

  scan_reg_bank #(.NQUAD(NQUAD), .IOC(IOC), .BUR(BUR)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .shift_i   (shift_pulse),
    .freeze_i  (active),
    .sdi_i     (sdi_i),
    .func_en_i (func_en_i),
    .func_d_i  (func_d_i),
    .cfg_t_i   (cfg_t_i),
    .regs_o    (regs_o),
    .tail_o    (tail)
  );

  scan_viol_mon #(.NQUAD(NQUAD)) u_viol (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_chg_i (mode_chg),
    .usr_clk_i  (usr_clk_i),
    .tck_i      (tck_i),
    .viol_o     (viol_o)
  );

  assign sdo_o    = active & tail;
  assign sdo_en_o = active & ~sdo_oe_n_i;
endmodule

// File: rtl/scan_preload_chk.sv
module scan_preload_chk
  import scan_pkg::*;
#(
  parameter int NQUAD = 4,
  parameter int IOC   = 13,
  parameter int BUR   = 6,
  localparam int NREG = NQUAD * (2 * IOC + BUR)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            test_mode_i,
  input logic            lock_i,
  input logic            sdi_i,
  input logic            sdo_oe_n_i,
  input logic [NREG-1:0] regs_o,
  input logic            sdo_o,
  input logic            sdo_en_o,
  input logic            viol_o,
  input logic            active,
  input logic            shift_pulse
);
  localparam int HEAD  = nat_of_pos(0, IOC, BUR);
  localparam int PRE_T = nat_of_pos(NREG - 2, IOC, BUR);

  // R2: the head of the chain takes the serial input on a shift
  a_r2_head_load: assert property (@(posedge clk) disable iff (!rst_n)
    shift_pulse |=> regs_o[HEAD] == $past(sdi_i));

  // R9: no change while in the mode without a shift
  a_r9_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !shift_pulse) |=> $stable(regs_o));

  // R4: the output follows the register one step before the tail
  a_r4_tail_follow: assert property (@(posedge clk) disable iff (!rst_n)
    shift_pulse |=> (!active || sdo_o == $past(regs_o[PRE_T])));

  // R6: output drive only when active and enabled
  a_r6_drive_gate: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_en_o |-> (test_mode_i && !lock_i && !sdo_oe_n_i));

  // R7: lock blocks shifting and output drive
  a_r7_lock_block: assert property (@(posedge clk) disable iff (!rst_n)
    lock_i |-> (!sdo_en_o && !shift_pulse));

  // R8: violation flag is sticky
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    viol_o |=> viol_o);

  // R10: quiet serial output outside the mode
  a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(test_mode_i && !lock_i) |-> !sdo_o);
endmodule

bind scan_preload_ctrl scan_preload_chk #(.NQUAD(NQUAD), .IOC(IOC), .BUR(BUR)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .test_mode_i (test_mode_i),
  .lock_i      (lock_i),
  .sdi_i       (sdi_i),
  .sdo_oe_n_i  (sdo_oe_n_i),
  .regs_o      (regs_o),
  .sdo_o       (sdo_o),
  .sdo_en_o    (sdo_en_o),
  .viol_o      (viol_o),
  .active      (active),
  .shift_pulse (shift_pulse)
);

// File: tb/scan_preload_ctrl_test.sv
module scan_preload_ctrl_test;
  localparam int NREG  = 128;
  localparam int NQUAD = 4;
  localparam int NTBL  = 9;
  // walk table: scan depth and the natural bit expected to hold the marker (R3)
  localparam int TBL_POS [NTBL] = '{0, 1, 4, 5, 29, 31, 32, 36, 127};
  localparam int TBL_NAT [NTBL] = '{0, 1, 26, 4, 31, 25, 32, 58, 121};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NREG-1:0] func_en_i = '0, func_d_i = '0, cfg_t_i = '0;
  logic [NQUAD-1:0] usr_clk_i = '0;
  logic test_mode_i = 1'b0, tck_i = 1'b0, sdi_i = 1'b0;
  logic sdo_oe_n_i = 1'b0, lock_i = 1'b0;
  logic [NREG-1:0] regs_o;
  logic sdo_o, sdo_en_o, viol_o;

  int nchk = 0;
  int nfail = 0;
  logic [NREG-1:0] pat, snap;

  always #2.5 clk = ~clk;

  scan_preload_ctrl uut (
    .clk(clk), .rst_n(rst_n), .func_en_i(func_en_i), .func_d_i(func_d_i),
    .cfg_t_i(cfg_t_i), .usr_clk_i(usr_clk_i), .test_mode_i(test_mode_i),
    .tck_i(tck_i), .sdi_i(sdi_i), .sdo_oe_n_i(sdo_oe_n_i), .lock_i(lock_i),
    .regs_o(regs_o), .sdo_o(sdo_o), .sdo_en_o(sdo_en_o), .viol_o(viol_o)
  );

  task automatic chk(input logic ok, input string req,
                     input logic [NREG-1:0] act, input logic [NREG-1:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; test_mode_i = 1'b0; tck_i = 1'b0; lock_i = 1'b0;
    func_en_i = '0; usr_clk_i = '0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // tck held high two clocks: must shift once only (R2)
  task automatic pulse(input logic b);
    sdi_i = b;
    tck_i = 1'b1;
    @(negedge clk);
    @(negedge clk);
    tck_i = 1'b0;
    @(negedge clk);
  endtask

  task automatic set_mode(input logic m);
    test_mode_i = m;
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(5ns * 150000);
    nchk++; nfail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    do_reset();
    chk(regs_o == '0, "R1 registers", regs_o, '0);
    chk({sdo_o, sdo_en_o, viol_o} == 3'b000, "R1 outputs", NREG'({sdo_o, sdo_en_o, viol_o}), '0);

    // table walk: marker placement (R2, R3)
    for (int i = 0; i < NTBL; i++) begin
      do_reset();
      set_mode(1'b1);
      pulse(1'b1);
      for (int k = 0; k < TBL_POS[i]; k++) pulse(1'b0);
      chk(regs_o == (NREG'(1) << TBL_NAT[i]), "R3 R2 marker position",
          regs_o, NREG'(1) << TBL_NAT[i]);
      set_mode(1'b0);
    end

    // preload into toggle-type registers with output disabled (R5, R6)
    do_reset();
    cfg_t_i = '1;
    sdo_oe_n_i = 1'b1;
    set_mode(1'b1);
    chk(sdo_en_o == 1'b0, "R6 drive off while oe_n high", NREG'(sdo_en_o), '0);
    for (int s = 0; s < NREG; s++) begin
      pat[s] = ((s * 7 + 3) % 5) < 2;
      pulse(pat[s]);
    end
    chk($countones(regs_o) == $countones(pat), "R5 raw preload count",
        NREG'($countones(regs_o)), NREG'($countones(pat)));
    snap = regs_o;
    sdo_oe_n_i = 1'b0;
    #1;
    chk(sdo_en_o == 1'b1, "R6 drive on", NREG'(sdo_en_o), NREG'(1));

    // loopback observation: FIFO order and no loss (R4)
    begin
      int bad;
      bad = 0;
      for (int s = 0; s < NREG; s++) begin
        if (sdo_o !== pat[s]) bad++;
        pulse(sdo_o);
      end
      chk(bad == 0, "R4 FIFO order mismatches", NREG'(bad), '0);
    end
    chk(regs_o == snap, "R4 state kept after loopback", regs_o, snap);

    // frozen in mode, kept and resumed after exit (R9)
    func_en_i = '1; func_d_i = '1;
    @(negedge clk); @(negedge clk);
    chk(regs_o == snap, "R9 frozen in mode", regs_o, snap);
    func_en_i = '0;
    set_mode(1'b0);
    chk(regs_o == snap, "R9 kept after exit", regs_o, snap);
    chk(sdo_o == 1'b0, "R10 quiet after exit", NREG'(sdo_o), '0);
    cfg_t_i = '0; cfg_t_i[5] = 1'b1;
    func_d_i = '0; func_d_i[5] = 1'b1; func_d_i[6] = 1'b1;
    func_en_i[5] = 1'b1; func_en_i[6] = 1'b1;
    @(negedge clk);
    func_en_i = '0;
    begin
      logic [NREG-1:0] e;
      e = snap; e[5] = ~snap[5]; e[6] = 1'b1;
      chk(regs_o == e, "R9 toggle and D update resume", regs_o, e);
      snap = e;
    end

    // lock: no shift, no drive, function continues (R7)
    lock_i = 1'b1;
    set_mode(1'b1);
    pulse(~regs_o[0]);
    chk(regs_o == snap, "R7 no shift under lock", regs_o, snap);
    chk({sdo_en_o, sdo_o} == 2'b00, "R7 R10 no drive under lock", NREG'({sdo_en_o, sdo_o}), '0);
    func_en_i[6] = 1'b1; func_d_i[6] = 1'b0;
    @(negedge clk);
    func_en_i = '0;
    chk(regs_o[6] == 1'b0, "R7 function runs under lock", NREG'(regs_o[6]), '0);
    chk(viol_o == 1'b0, "R8 clean so far", NREG'(viol_o), '0);

    // clock rule (R8)
    do_reset();
    set_mode(1'b1);
    set_mode(1'b0);
    chk(viol_o == 1'b0, "R8 clean entry and exit", NREG'(viol_o), '0);
    usr_clk_i[2] = 1'b1;
    set_mode(1'b1);
    usr_clk_i = '0;
    chk(viol_o == 1'b1, "R8 entry with clock high", NREG'(viol_o), NREG'(1));
    set_mode(1'b0);
    chk(viol_o == 1'b1, "R8 sticky", NREG'(viol_o), NREG'(1));
    do_reset();
    set_mode(1'b1);
    tck_i = 1'b1;
    set_mode(1'b0);
    tck_i = 1'b0;
    chk(viol_o == 1'b1, "R8 exit with test clock high", NREG'(viol_o), NREG'(1));

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule